// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block holds the software-visible control and status state of an ECC memory controller. A host reaches nine 32-bit registers through a plain word bus: a select, a write strobe, a word address, byte lanes, write data and combinational read data. The registers are: an enable register, a delay register, a fault status register, a video configuration word, two fault address words, a diagnostic word and two event counters. A datapath next to the bank reports faults through a capture port. A capture updates the status fields, loads the fault address, and may raise the single interrupt line.

A `VARIANT` parameter (0, 1 or 2) selects the chip flavour. It sets which enable bits a write may change, which enable bits survive a reset, and the implementation code held in the top nibble of the enable register. Only variant 0 adds a small byte-wide diagnostic scratch window of four bytes, reached on its own port.

Top module: `ecc_ctl_regbank`

## Requirements
- R1: After reset the bank reads: delay 0x00000020, fault address 0 at 0x07C00000, and status, video, fault address 1, diagnostic and both counters at 0. The interrupt is low.
- R2: The enable register sits at word index 0 (address bits [5:2]). A write there keeps the data bits in mask 0x00000103 for variant 0. For variants 1 and 2 it keeps the bits in mask 0x00000BFF, and bits [31:28] always read the variant number (1 or 2).
- R3: A reset changes only part of the enable register. Variant 0 keeps bit 8 and clears the rest. Variants 1 and 2 keep bits [31:24], bits [9:2] and bit 11, and clear the rest.
- R4: The delay register (index 1) stores a write with bit 31 forced to 0.
- R5: A write to the status register (index 2) stores the full word and drops the interrupt, unless a capture happens in the same cycle.
- R6: The fault address words (index 4 and 5) are read-only. Bus writes to them leave them unchanged.
- R7: A write takes effect only when all four byte lanes are enabled (be = 4'hF). Any other lane pattern changes nothing.
- R8: A capture ORs bit 0 (correctable) or bit 3 (uncorrectable) into the status register. It loads bits [7:4] with the double-word index and bits [15:8] with the syndrome. It loads fault address 1 with PA[31:0], and bits [3:0] of fault address 0 with PA[35:32].
- R9: A capture that arrives while status bit 0 or bit 3 is already set also sets status bit 16 (multiple errors).
- R10: An uncorrectable capture always raises the interrupt, one cycle later. A correctable capture raises it only when enable bits 0 and 1 are both set.
- R11: When a capture and a status write fall in the same cycle, the capture wins. The status becomes the capture result built on the old value, and the written data is dropped.
- R12: The video (3), diagnostic (6) and counter (7, 8) registers each store all 32 bits written, and the two counters are separate. Reads of indices 9 to 15 return 0.
- R13: With variant 0, the diagnostic window stores one byte for each of the four addresses given by its 2-bit address and returns it on read. With other variants, the window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | AW (6) | Byte address; bits [5:2] pick the word |
| bus_be | input | 4 | Byte lane enables; a write needs all four |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| dg_sel | input | 1 | Diagnostic window strobe |
| dg_wr | input | 1 | Diagnostic window write |
| dg_addr | input | 2 | Diagnostic byte address |
| dg_wdata | input | 8 | Diagnostic write byte |
| dg_rdata | output | 8 | Diagnostic read byte |
| cap_ce | input | 1 | Correctable fault pulse |
| cap_ue | input | 1 | Uncorrectable fault pulse |
| cap_syn | input | 8 | Fault syndrome |
| cap_dw | input | 4 | Double-word index of the fault |
| cap_pa | input | PA_W (36) | Physical address of the fault |
| irq | output | 1 | Fault interrupt |

## Verification
The bench runs a variant-0 and a variant-1 instance side by side. It sweeps every word index with several data patterns and predicts each read from the masks. A wrong mask, a missing implementation code or a writable fault address word shows up as a mismatch at a single index. A second test writes all ones to the enable register, then resets. A design that cleared the whole register, or kept the wrong field for its variant, reads back the wrong word. The fault tests cover four cases: a capture on top of a pending fault (the multiple-error bit), a correctable fault with interrupts masked (a spurious interrupt), a status write that should lower the interrupt, and a status write that collides with a capture (the capture must win).

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 9;
    localparam int DG_BYTES = 4;
    localparam int DG_AW    = $clog2(DG_BYTES);

    typedef enum logic [3:0] {
        IDX_EN   = 4'd0,
        IDX_DLY  = 4'd1,
        IDX_STS  = 4'd2,
        IDX_VID  = 4'd3,
        IDX_FA0  = 4'd4,
        IDX_FA1  = 4'd5,
        IDX_DIAG = 4'd6,
        IDX_CNT0 = 4'd7,
        IDX_CNT1 = 4'd8
    } reg_idx_e;

    localparam logic [DATA_W-1:0] DLY_RST  = 32'h0000_0020;
    localparam logic [DATA_W-1:0] DLY_MASK = 32'h7FFF_FFFF;
    localparam logic [DATA_W-1:0] FA0_RST  = 32'h07C0_0000;
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    // Status word layout
    typedef struct packed {
        logic [13:0] rsvd;
        logic        gfx_err;
        logic        multi;
        logic [7:0]  syn;
        logic [3:0]  dw;
        logic        ue;
        logic        wr_tmo;
        logic        bad_slot;
        logic        ce;
    } fault_sts_t;

    function automatic logic [DATA_W-1:0] en_code(input int variant);
        return (variant == 0) ? '0 : (DATA_W'(variant) << 28);
    endfunction

    function automatic logic [DATA_W-1:0] en_wmask(input int variant);
        return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [DATA_W-1:0] en_keep(input int variant);
        return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

endpackage

// File: rtl/ecc_word_reg.sv
module ecc_word_reg
    import ecc_regs_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter logic [DATA_W-1:0] WMASK   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= d & WMASK;
    end
endmodule

// File: rtl/ecc_enable_reg.sv
module ecc_enable_reg
    import ecc_regs_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] CODE  = en_code(VARIANT);
    localparam logic [DATA_W-1:0] WMASK = en_wmask(VARIANT);
    localparam logic [DATA_W-1:0] KEEP  = en_keep(VARIANT);

    // Kept fields survive reset, so the register starts from a power-up value.
    logic [DATA_W-1:0] en_q = CODE;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= (en_q & KEEP) | CODE;
        else if (we)
            en_q <= (d & WMASK) | CODE;
    end

    assign q = en_q;
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
    import ecc_regs_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sts_we,
    input  logic [DATA_W-1:0] sts_wdata,
    input  logic              cap_ce,
    input  logic              cap_ue,
    input  logic [7:0]        cap_syn,
    input  logic [3:0]        cap_dw,
    input  logic [PA_W-1:0]   cap_pa,
    input  logic              ce_irq_en,
    output logic [DATA_W-1:0] sts_q,
    output logic [DATA_W-1:0] far0_q,
    output logic [DATA_W-1:0] far1_q,
    output logic              irq
);
    localparam int HI_W = PA_W - DATA_W;

    fault_sts_t sts_r, sts_cap;
    logic       cap_any, pending, raise;

    assign cap_any = cap_ce | cap_ue;
    assign pending = sts_r.ce | sts_r.ue;
    assign raise   = cap_ue | (cap_ce & ce_irq_en);

    always_comb begin
        sts_cap       = sts_r;
        sts_cap.ce    = sts_r.ce | cap_ce;
        sts_cap.ue    = sts_r.ue | cap_ue;
        sts_cap.multi = sts_r.multi | pending;
        sts_cap.syn   = cap_syn;
        sts_cap.dw    = cap_dw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_r  <= '0;
            far0_q <= FA0_RST;
            far1_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (cap_any) begin
                sts_r  <= sts_cap;
                far0_q <= {far0_q[DATA_W-1:HI_W], cap_pa[PA_W-1:DATA_W]};
                far1_q <= cap_pa[DATA_W-1:0];
            end else if (sts_we) begin
                sts_r <= fault_sts_t'(sts_wdata);
            end
            if (raise)
                irq <= 1'b1;
            else if (sts_we)
                irq <= 1'b0;
        end
    end

    assign sts_q = sts_r;

    // R5
    sts_clr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (sts_we && !cap_ce && !cap_ue) |=> !irq);

    // R10
    ue_irq_chk: assert property (@(posedge clk) disable iff (rst)
        cap_ue |=> irq);

    // R10
    ce_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_ce && !cap_ue && !ce_irq_en && !irq) |=> !irq);

    // R9
    multi_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_any && (sts_q[0] || sts_q[3])) |=> sts_q[16]);

    // R11
    cap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_any && sts_we) |=> (sts_q[0] || sts_q[3]));
endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window
    import ecc_regs_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr,
    input  logic [DG_AW-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    if (PRESENT) begin : g_win
        logic [7:0] bytes_q [DG_BYTES];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DG_BYTES; i++) bytes_q[i] <= '0;
            end else if (sel && wr) begin
                bytes_q[addr] <= wdata;
            end
        end
        assign rdata = bytes_q[addr];
    end else begin : g_none
        logic unused_in;
        assign unused_in = ^{clk, rst, sel, wr, addr, wdata};
        assign rdata     = '0;
    end
endmodule

// File: rtl/ecc_ctl_regbank.sv
module ecc_ctl_regbank
    import ecc_regs_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int AW      = 6,
    parameter int PA_W    = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dg_sel,
    input  logic              dg_wr,
    input  logic [DG_AW-1:0]  dg_addr,
    input  logic [7:0]        dg_wdata,
    output logic [7:0]        dg_rdata,
    input  logic              cap_ce,
    input  logic              cap_ue,
    input  logic [7:0]        cap_syn,
    input  logic [3:0]        cap_dw,
    input  logic [PA_W-1:0]   cap_pa,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CODE = en_code(VARIANT);

    reg_idx_e          idx;
    logic              wr_full;
    logic [15:0]       we_vec;
    logic [DATA_W-1:0] en_q, dly_q, sts_q, vid_q, far0_q, far1_q, diag_q, cnt0_q, cnt1_q;
    logic [1:0]        unused_lsb;

    assign unused_lsb = bus_addr[1:0];
    assign idx        = reg_idx_e'(bus_addr[5:2]);
    assign wr_full    = bus_sel && bus_wr && (bus_be == 4'hF);

    for (genvar g = 0; g < 16; g++) begin : g_dec
        assign we_vec[g] = wr_full && (bus_addr[5:2] == 4'(g));
    end

    ecc_enable_reg #(.VARIANT(VARIANT)) u_en (
        .clk(clk), .rst(rst), .we(we_vec[IDX_EN]), .d(bus_wdata), .q(en_q));

    ecc_word_reg #(.RST_VAL(DLY_RST), .WMASK(DLY_MASK)) u_dly (
        .clk(clk), .rst(rst), .we(we_vec[IDX_DLY]), .d(bus_wdata), .q(dly_q));
    ecc_word_reg #(.RST_VAL('0), .WMASK(ALL_ONES)) u_vid (
        .clk(clk), .rst(rst), .we(we_vec[IDX_VID]), .d(bus_wdata), .q(vid_q));
    ecc_word_reg #(.RST_VAL('0), .WMASK(ALL_ONES)) u_diag (
        .clk(clk), .rst(rst), .we(we_vec[IDX_DIAG]), .d(bus_wdata), .q(diag_q));
    ecc_word_reg #(.RST_VAL('0), .WMASK(ALL_ONES)) u_cnt0 (
        .clk(clk), .rst(rst), .we(we_vec[IDX_CNT0]), .d(bus_wdata), .q(cnt0_q));
    ecc_word_reg #(.RST_VAL('0), .WMASK(ALL_ONES)) u_cnt1 (
        .clk(clk), .rst(rst), .we(we_vec[IDX_CNT1]), .d(bus_wdata), .q(cnt1_q));

    ecc_fault_capture #(.PA_W(PA_W)) u_flt (
        .clk(clk), .rst(rst),
        .sts_we(we_vec[IDX_STS]), .sts_wdata(bus_wdata),
        .cap_ce(cap_ce), .cap_ue(cap_ue), .cap_syn(cap_syn), .cap_dw(cap_dw),
        .cap_pa(cap_pa), .ce_irq_en(en_q[0] & en_q[1]),
        .sts_q(sts_q), .far0_q(far0_q), .far1_q(far1_q), .irq(irq));

    ecc_diag_window #(.PRESENT(VARIANT == 0)) u_win (
        .clk(clk), .rst(rst), .sel(dg_sel), .wr(dg_wr), .addr(dg_addr),
        .wdata(dg_wdata), .rdata(dg_rdata));

    always_comb begin
        case (idx)
            IDX_EN:   bus_rdata = en_q;
            IDX_DLY:  bus_rdata = dly_q;
            IDX_STS:  bus_rdata = sts_q;
            IDX_VID:  bus_rdata = vid_q;
            IDX_FA0:  bus_rdata = far0_q;
            IDX_FA1:  bus_rdata = far1_q;
            IDX_DIAG: bus_rdata = diag_q;
            IDX_CNT0: bus_rdata = cnt0_q;
            IDX_CNT1: bus_rdata = cnt1_q;
            default:  bus_rdata = '0;
        endcase
    end

    // R2
    en_code_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[5:2] == 4'd0) |-> (bus_rdata[31:28] == CODE[31:28]));

    // R4
    dly_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[5:2] == 4'd1) |-> !bus_rdata[31]);

    // R6
    far_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !cap_ce && !cap_ue) |=> ($stable(far0_q) && $stable(far1_q)));

    // R7
    partial_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_be != 4'hF) |=> ($stable(dly_q) && $stable(vid_q) && $stable(en_q)));
endmodule

// File: tb/sim_ecc_ctl_regbank.sv
`timescale 1ns/1ps
module sim_ecc_ctl_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        dg_sel = 0, dg_wr = 0;
    logic [1:0]  dg_addr = '0;
    logic [7:0]  dg_wdata = '0;
    logic        cap_ce = 0, cap_ue = 0;
    logic [7:0]  cap_syn = '0;
    logic [3:0]  cap_dw = '0;
    logic [35:0] cap_pa = '0;
    logic [31:0] rd0, rd1;
    logic [7:0]  dg0, dg1;
    logic        irq0, irq1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ecc_ctl_regbank #(.VARIANT(0)) u0 (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata(rd0),
        .dg_sel, .dg_wr, .dg_addr, .dg_wdata, .dg_rdata(dg0),
        .cap_ce, .cap_ue, .cap_syn, .cap_dw, .cap_pa, .irq(irq0));

    ecc_ctl_regbank #(.VARIANT(1)) u1 (
        .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata, .bus_rdata(rd1),
        .dg_sel, .dg_wr, .dg_addr, .dg_wdata, .dg_rdata(dg1),
        .cap_ce, .cap_ue, .cap_syn, .cap_dw, .cap_pa, .irq(irq1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(idx << 2); bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd(input int idx);
        @(negedge clk);
        bus_addr = 6'(idx << 2);
        #1;
    endtask

    task automatic cap(input logic ce, input logic ue, input logic [7:0] s,
                       input logic [3:0] dw, input logic [35:0] pa);
        @(negedge clk);
        cap_ce = ce; cap_ue = ue; cap_syn = s; cap_dw = dw; cap_pa = pa;
        @(negedge clk);
        cap_ce = 0; cap_ue = 0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    function automatic logic [31:0] exp_en(input int v, input logic [31:0] d);
        return (v == 0) ? (d & 32'h103) : ((d & 32'hBFF) | (32'(v) << 28));
    endfunction

    task automatic check_reset_state();
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            rd(i);
            e = (i == 1) ? 32'h20 : (i == 4) ? 32'h07C0_0000 : 32'h0;
            if (i == 0) begin
                chk("R1 v0 idx0", rd0, 32'h0);
                chk("R1 v1 idx0", rd1, 32'h1000_0000);
            end else begin
                chk("R1 v0", rd0, e);
                chk("R1 v1", rd1, e);
            end
        end
        chk("R1 irq", {30'b0, irq1, irq0}, 32'h0);
    endtask

    function automatic string req_of(input int i);
        case (i)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            4, 5: return "R6";
            default: return "R12";
        endcase
    endfunction

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5;
        pats[2] = 32'h5A5A_5A5A; pats[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        rst = 0;
        check_reset_state();

        // Sweep every index with several patterns (R2 R4 R5 R6 R12)
        foreach (pats[k]) begin
            for (int i = 0; i < 16; i++) wr(i, (i == 8) ? ~pats[k] : pats[k], 4'hF);
            for (int i = 0; i < 16; i++) begin
                logic [31:0] e;
                rd(i);
                case (i)
                    0: e = pats[k];
                    1: e = pats[k] & 32'h7FFF_FFFF;
                    2, 3, 6, 7: e = pats[k];
                    4: e = 32'h07C0_0000;
                    8: e = ~pats[k];
                    default: e = 32'h0;
                endcase
                if (i == 0) begin
                    chk("R2 v0", rd0, exp_en(0, e));
                    chk("R2 v1", rd1, exp_en(1, e));
                end else begin
                    chk(req_of(i), rd0, e);
                    chk(req_of(i), rd1, e);
                end
            end
        end

        // R7: partial lane writes are dropped
        wr(1, 32'h0, 4'h7);
        wr(3, 32'h0, 4'hE);
        rd(1); chk("R7 dly", rd0, 32'h1234_5678); chk("R7 dly", rd1, 32'h1234_5678);
        rd(3); chk("R7 vid", rd0, 32'h1234_5678); chk("R7 vid", rd1, 32'h1234_5678);

        // R3: enable preservation over reset
        wr(0, 32'hFFFF_FFFF, 4'hF);
        do_reset();
        rd(0);
        chk("R3 v0", rd0, 32'h0000_0100);
        chk("R3 v1", rd1, 32'h1000_0BFC);
        for (int i = 1; i < 9; i++) begin
            rd(i);
            chk("R1 after reset", rd0, (i == 1) ? 32'h20 : (i == 4) ? 32'h07C0_0000 : 32'h0);
        end

        // R8 R10: correctable, interrupt masked
        cap(1, 0, 8'hA5, 4'h3, 36'h5_1234_5678);
        chk("R10 ce masked", {30'b0, irq1, irq0}, 32'h0);
        rd(2); chk("R8 sts", rd0, 32'h0000_A531); chk("R8 sts", rd1, 32'h0000_A531);
        rd(4); chk("R8 far0", rd0, 32'h07C0_0005);
        rd(5); chk("R8 far1", rd1, 32'h1234_5678);

        // R9 R10: uncorrectable on pending fault
        cap(0, 1, 8'h3C, 4'h7, 36'h0_0000_0040);
        chk("R10 ue", {30'b0, irq1, irq0}, 32'h3);
        rd(2); chk("R9 sts", rd0, 32'h0001_3C79); chk("R9 sts", rd1, 32'h0001_3C79);
        rd(4); chk("R8 far0", rd1, 32'h07C0_0000);
        rd(5); chk("R8 far1", rd0, 32'h0000_0040);

        // R5: status write clears interrupt
        wr(2, 32'h0, 4'hF);
        #1;
        chk("R5 irq", {30'b0, irq1, irq0}, 32'h0);
        rd(2); chk("R5 sts", rd0, 32'h0);

        // R10: correctable with both enable bits set
        wr(0, 32'h3, 4'hF);
        rd(0); chk("R2 v0", rd0, 32'h3); chk("R2 v1", rd1, 32'h1000_0003);
        cap(1, 0, 8'h5A, 4'h1, 36'h0);
        chk("R10 ce enabled", {30'b0, irq1, irq0}, 32'h3);
        rd(2); chk("R8 sts", rd0, 32'h0000_5A11);
        wr(2, 32'h0, 4'hF);

        // R11: capture and status write collide
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'd8; bus_be = 4'hF; bus_wdata = 32'hFFFF_0000;
        cap_ue = 1; cap_syn = 8'h11; cap_dw = 4'h2; cap_pa = '0;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; cap_ue = 0;
        #1;
        chk("R11 irq", {30'b0, irq1, irq0}, 32'h3);
        rd(2); chk("R11 sts", rd0, 32'h0000_1128); chk("R11 sts", rd1, 32'h0000_1128);

        // R13: diagnostic byte window
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            dg_sel = 1; dg_wr = 1; dg_addr = 2'(b); dg_wdata = 8'(8'hC0 + b * 3);
        end
        @(negedge clk); dg_sel = 0; dg_wr = 0;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk); dg_addr = 2'(b); #1;
            chk("R13 v0", {24'b0, dg0}, 32'(8'hC0 + b * 3));
            chk("R13 v1", {24'b0, dg1}, 32'h0);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule